// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block turns a start/stop framed serial line into parallel characters. It runs on one receive clock, and a programmable divisor gives the length of one bit in clock cycles. The line is watched for a falling edge. That edge is confirmed by a second look half a bit later, so that short glitches do not start a character. The block then takes one sample in the middle of each data bit, of the optional parity bit and of one or two stop bits.

Each finished character is placed in a holding register and a ready flag is raised. Parity, framing and overrun flags are updated in the same cycle as the holding register. A line held low through a whole character counts as a break. A break produces one all-zero character with the framing flag set. The receiver then waits for the line to go high again before it looks for a new start bit.

The surrounding logic sets the character length, the parity mode and the stop count. It pulses a read strobe when it takes a character.

Top module: `async_rx`

## Requirements
- R1: Characters are received only while `carrier_n` is 0 and `rx_en` is 1. While either condition fails, no character completes and the receiver returns to hunting.
- R2: A falling edge is confirmed by sampling the line half a bit-time (`bit_div`/2 cycles) later. If the line is high at that point, the edge is dropped and no character is produced.
- R3: Data bits are sampled once per `bit_div` cycles, least significant bit first. The number of data bits is 5 + `char_len` (`char_len` 0 gives 5 bits, 3 gives 8 bits).
- R4: When the last stop bit has been sampled, the character is written to `rx_data` and `rx_ready` goes to 1.
- R5: For characters shorter than 8 bits, the unused upper bits of `rx_data` read as 0.
- R6: With `par_en` 1, a parity bit follows the data. `par_odd` 0 selects even parity (data plus parity bit hold an even number of ones) and 1 selects odd parity. `parity_err` is set when the received parity bit is wrong. With `par_en` 0, `parity_err` is 0.
- R7: `frame_err` is set when any sampled stop bit is low. The error flags are updated only in the cycle a character completes.
- R8: A break is a character whose start, data, parity and stop samples are all low. It delivers exactly one character equal to 0, with `frame_err` 1 and `parity_err` 0.
- R9: After a break, no new character starts until the line has been high.
- R10: If a character completes while `rx_ready` is 1 and no read is under way, `overrun_err` is set and the new character replaces the old one. Otherwise `overrun_err` is cleared at completion.
- R11: A `rd_strobe` pulse clears `rx_ready`. Dropping `rx_en` also clears `rx_ready`.
- R12: With `two_stop` 1, two stop bits are sampled. A low second stop bit sets `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial data line, idle high |
| carrier_n | input | 1 | Carrier detect, active low |
| rx_en | input | 1 | Receiver enable |
| bit_div | input | DIV_W | Clock cycles per bit (at least 4) |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| rd_strobe | input | 1 | Holding register read pulse |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character available |
| parity_err | output | 1 | Parity error of the last character |
| frame_err | output | 1 | Framing error of the last character |
| overrun_err | output | 1 | Last character overwrote an unread one |

## Verification
Some properties are checked by the assertions on every cycle. Ready can only rise from a completion event. Upper bits are zero after a short character. A break always gives a zero character with only the framing flag set. Overrun follows the ready state at completion. A read or a disable clears ready. An inactive receiver stays idle. A break keeps the receiver parked while the line is low.

Other behaviour shows only in the bench's scenarios, which drive real frames. These cover bit order and value per length, the parity sense, rejection of a glitch shorter than half a bit, the single delivery of a long break, and the second stop bit check.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKW
  } rx_state_e;

  // number of data bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // mask of valid data bits for a length code
  function automatic logic [7:0] char_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // parity check: total ones of data and parity bit must match the mode
  function automatic logic parity_bad(input logic [7:0] d, input logic pbit,
                                      input logic odd);
    return (^d ^ pbit) != odd;
  endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half = div >> 1;
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (arm)          cnt <= half - 1'b1;
    else if (!run)         cnt <= '0;
    else if (cnt == '0)    cnt <= div - 1'b1;
    else                   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import async_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       line,
  input  logic       line_fell,
  input  logic       tick,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       arm,
  output logic       run,
  output logic       busy,
  output logic       brk_wait,
  output logic       char_done,
  output logic [7:0] char_data,
  output logic       par_bad,
  output logic       frm_bad,
  output logic       brk_det
);
  rx_state_e  state;
  logic [7:0] shreg;
  logic [2:0] idx;
  logic       any_one;
  logic       pbit;
  logic       stop_idx;
  logic       stop_low;
  logic       stop_high;
  logic       last_stop;

  assign arm       = active && (state == ST_IDLE) && line_fell;
  assign run       = (state != ST_IDLE) && (state != ST_BRKW);
  assign busy      = (state != ST_IDLE);
  assign brk_wait  = (state == ST_BRKW);
  assign last_stop = !two_stop || stop_idx;
  assign char_done = active && (state == ST_STOP) && tick && last_stop;
  assign char_data = shreg;
  assign frm_bad   = stop_low || !line;
  assign brk_det   = !any_one && !stop_high && !line;
  assign par_bad   = par_en && parity_bad(shreg, pbit, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; shreg <= '0; idx <= '0; any_one <= 1'b0;
      pbit <= 1'b0; stop_idx <= 1'b0; stop_low <= 1'b0; stop_high <= 1'b0;
    end else if (!active) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (line_fell) begin
          state <= ST_START; shreg <= '0; idx <= '0; any_one <= 1'b0;
          pbit <= 1'b0; stop_idx <= 1'b0; stop_low <= 1'b0; stop_high <= 1'b0;
        end
        ST_START: if (tick) state <= line ? ST_IDLE : ST_DATA;
        ST_DATA: if (tick) begin
          shreg[idx] <= line;
          any_one    <= any_one | line;
          idx        <= idx + 1'b1;
          if ({1'b0, idx} == char_bits(char_len) - 4'd1)
            state <= par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (tick) begin
          pbit    <= line;
          any_one <= any_one | line;
          state   <= ST_STOP;
        end
        ST_STOP: if (tick) begin
          if (!last_stop) begin
            stop_idx  <= 1'b1;
            stop_low  <= stop_low | !line;
            stop_high <= stop_high | line;
          end else begin
            state <= brk_det ? ST_BRKW : ST_IDLE;
          end
        end
        ST_BRKW: if (line) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_holding.sv
module rx_holding (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rd_strobe,
  input  logic       char_done,
  input  logic [7:0] char_data,
  input  logic       par_bad,
  input  logic       frm_bad,
  input  logic       brk_det,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_ready <= 1'b0;
      parity_err <= 1'b0; frame_err <= 1'b0; overrun_err <= 1'b0;
    end else if (char_done) begin
      rx_data     <= brk_det ? 8'h00 : char_data;
      rx_ready    <= 1'b1;
      parity_err  <= brk_det ? 1'b0 : par_bad;
      frame_err   <= frm_bad;
      overrun_err <= rx_ready && !rd_strobe;
    end else if (rd_strobe || !rx_en) begin
      rx_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             carrier_n,
  input  logic             rx_en,
  input  logic [DIV_W-1:0] bit_div,
  input  logic [1:0]       char_len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic             rd_strobe,
  output logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             parity_err,
  output logic             frame_err,
  output logic             overrun_err
);
  logic       line, line_prev, line_fell, active;
  logic       arm, run, tick, busy, brk_wait;
  logic       char_done, par_bad, frm_bad, brk_det;
  logic [7:0] char_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line      <= 1'b1;
      line_prev <= 1'b1;
    end else begin
      line      <= rxd;
      line_prev <= line;
    end
  end

  assign line_fell = line_prev && !line;
  assign active    = !carrier_n && rx_en;

  rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .run(run), .div(bit_div), .tick(tick)
  );

  rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .active(active), .line(line),
    .line_fell(line_fell), .tick(tick), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .arm(arm), .run(run), .busy(busy), .brk_wait(brk_wait),
    .char_done(char_done), .char_data(char_data), .par_bad(par_bad),
    .frm_bad(frm_bad), .brk_det(brk_det)
  );

  rx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
    .char_done(char_done), .char_data(char_data), .par_bad(par_bad),
    .frm_bad(frm_bad), .brk_det(brk_det), .rx_data(rx_data),
    .rx_ready(rx_ready), .parity_err(parity_err), .frame_err(frame_err),
    .overrun_err(overrun_err)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk
  import async_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       rx_en,
  input logic       line,
  input logic       rd_strobe,
  input logic [1:0] char_len,
  input logic       busy,
  input logic       brk_wait,
  input logic       char_done,
  input logic       brk_det,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       parity_err,
  input logic       frame_err,
  input logic       overrun_err
);
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !busy);
  p_no_done_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !char_done);
  p_ready_from_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(char_done));
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> ((rx_data & ~char_mask($past(char_len))) == 8'h00));
  p_break_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && brk_det) |=> (rx_data == 8'h00 && frame_err && !parity_err));
  p_break_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_wait && !line && active) |=> brk_wait);
  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_ready && !rd_strobe) |=> overrun_err);
  p_overrun_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !rx_ready) |=> !overrun_err);
  p_read_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> !rx_ready);
  p_disable_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready);
endmodule

bind async_rx async_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .rx_en(rx_en), .line(line),
  .rd_strobe(rd_strobe), .char_len(char_len), .busy(busy),
  .brk_wait(brk_wait), .char_done(char_done), .brk_det(brk_det),
  .rx_data(rx_data), .rx_ready(rx_ready), .parity_err(parity_err),
  .frame_err(frame_err), .overrun_err(overrun_err)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       carrier_n = 1'b0;
  logic       rx_en = 1'b1;
  logic [7:0] bit_div = 8'(DIV);
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, frame_err, overrun_err;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  async_rx #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .carrier_n(carrier_n),
    .rx_en(rx_en), .bit_div(bit_div), .char_len(char_len), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_ready(rx_ready), .parity_err(parity_err),
    .frame_err(frame_err), .overrun_err(overrun_err)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rxd = lvl;
    end
  endtask

  task automatic cfg(input logic [1:0] len, input logic pe, input logic po,
                     input logic ts);
    @(negedge clk);
    char_len = len; par_en = pe; par_odd = po; two_stop = ts;
  endtask

  // one frame: start, data LSB first, optional parity (flip on bad), stops
  task automatic send(input logic [7:0] d, input logic bad_par,
                      input logic s0, input logic s1);
    int nb;
    logic pb;
    nb = 5 + int'(char_len);
    pb = 1'b0;
    for (int i = 0; i < nb; i++) pb ^= d[i];
    pb = pb ^ par_odd ^ bad_par;
    hold(1'b0, DIV);
    for (int i = 0; i < nb; i++) hold(d[i], DIV);
    if (par_en) hold(pb, DIV);
    hold(s0, DIV);
    if (two_stop) hold(s1, DIV);
    hold(1'b1, 3);
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 reset ready", rx_ready, 0);
    chk("R7 reset flags", {parity_err, frame_err, overrun_err}, 0);
  endtask

  task automatic t_basic();
    cfg(2'd3, 0, 0, 0);
    send(8'hA5, 0, 1, 1);
    chk("R3 data 8N1", rx_data, 8'hA5);
    chk("R4 ready", rx_ready, 1);
    chk("R7 no errors", {parity_err, frame_err, overrun_err}, 0);
    do_read();
    chk("R11 read clears ready", rx_ready, 0);
    send(8'h3C, 0, 1, 1);
    chk("R3 data second pattern", rx_data, 8'h3C);
    do_read();
  endtask

  task automatic t_len5();
    cfg(2'd0, 0, 0, 0);
    send(8'hFB, 0, 1, 1);
    chk("R5 upper bits zero len5", rx_data, 8'h1B);
    do_read();
    cfg(2'd1, 0, 0, 0);
    send(8'hEA, 0, 1, 1);
    chk("R5 upper bits zero len6", rx_data, 8'h2A);
    do_read();
  endtask

  task automatic t_parity();
    cfg(2'd2, 1, 0, 0);
    send(8'h55, 0, 1, 1);
    chk("R6 even parity ok", {rx_data, parity_err}, {8'h55, 1'b0});
    do_read();
    send(8'h55, 1, 1, 1);
    chk("R6 even parity bad", parity_err, 1);
    do_read();
    cfg(2'd3, 1, 1, 0);
    send(8'h81, 0, 1, 1);
    chk("R6 odd parity ok", {rx_data, parity_err}, {8'h81, 1'b0});
    do_read();
    send(8'h81, 1, 1, 1);
    chk("R6 odd parity bad", parity_err, 1);
    do_read();
    cfg(2'd3, 0, 0, 0);
  endtask

  task automatic t_framing();
    send(8'h7E, 0, 0, 0);
    chk("R7 framing error data", {rx_data, frame_err}, {8'h7E, 1'b1});
    do_read();
    send(8'h12, 0, 1, 1);
    chk("R7 framing cleared next char", frame_err, 0);
    do_read();
  endtask

  task automatic t_two_stop();
    cfg(2'd3, 0, 0, 1);
    send(8'hC3, 0, 1, 1);
    chk("R12 two stops ok", {rx_data, frame_err}, {8'hC3, 1'b0});
    do_read();
    send(8'hC3, 0, 1, 0);
    chk("R12 second stop low", frame_err, 1);
    do_read();
    cfg(2'd3, 0, 0, 0);
  endtask

  task automatic t_break();
    send(8'h5A, 0, 1, 1);
    do_read();
    hold(1'b0, DIV * 14);
    chk("R8 break ready", rx_ready, 1);
    chk("R8 break zero char", {rx_data, frame_err, parity_err}, {8'h00, 2'b10});
    do_read();
    hold(1'b0, DIV * 24);
    chk("R9 no char while line low", rx_ready, 0);
    hold(1'b1, DIV * 2);
    chk("R9 still none after idle", rx_ready, 0);
    send(8'h96, 0, 1, 1);
    chk("R9 hunt resumes after high", {rx_data, frame_err}, {8'h96, 1'b0});
    do_read();
  endtask

  task automatic t_false_start();
    hold(1'b0, DIV / 4);
    hold(1'b1, DIV * 12);
    chk("R2 glitch rejected", rx_ready, 0);
    send(8'h0F, 0, 1, 1);
    chk("R2 next char after glitch", rx_data, 8'h0F);
    do_read();
  endtask

  task automatic t_inactive();
    @(negedge clk); carrier_n = 1'b1;
    send(8'h44, 0, 1, 1);
    chk("R1 no char without carrier", rx_ready, 0);
    @(negedge clk); carrier_n = 1'b0; rx_en = 1'b0;
    send(8'h44, 0, 1, 1);
    chk("R1 no char while disabled", rx_ready, 0);
    @(negedge clk); rx_en = 1'b1;
    hold(1'b1, 4);
  endtask

  task automatic t_overrun();
    send(8'h11, 0, 1, 1);
    chk("R10 first no overrun", overrun_err, 0);
    send(8'h22, 0, 1, 1);
    chk("R10 overrun set and replaced", {rx_data, overrun_err}, {8'h22, 1'b1});
    do_read();
    send(8'h33, 0, 1, 1);
    chk("R10 overrun cleared", overrun_err, 0);
  endtask

  task automatic t_disable_clear();
    chk("R11 ready before disable", rx_ready, 1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    chk("R11 disable clears ready", rx_ready, 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_len5();
    t_parity();
    t_framing();
    t_two_stop();
    t_break();
    t_false_start();
    t_inactive();
    t_overrun();
    t_disable_clear();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule